// File: doc/BRIEF.md
# NAND Sector Hamming ECC Engine

This block computes a single-error-correcting parity code over one NAND sector while the sector's bytes stream past on a byte-wide strobed input. A start pulse arms a fresh calculation. Once the last byte of the sector has been accepted, the block raises a done flag, and the 24-bit code is then available on its output in the form that is written to the spare area.

The code has two 12-bit parity halves. The upper half collects the data bits whose bit position (byte offset times eight plus bit index) has a given address bit set. The lower half collects the data bits where that address bit is clear. The packed pair is inverted, so an erased sector of all ones yields an all-ones code.

On a read, the controller presents the code fetched from the spare area and pulses a check request. One clock later the block reports one of four outcomes: clean, one correctable data bit, a single flipped bit in the stored code, or uncorrectable. For a correctable error it also gives the byte offset and bit index to flip. Repairing the data buffer is left to the surrounding logic.

Top module: `nand_hamming_ecc`

## Requirements
- R1: `done_o` rises in the clock after the SECTOR_BYTES-th accepted byte strobe (default 512 bytes) and not earlier. It then stays high until the next start.
- R2: `code_o` equals the bitwise inverse of {upper, lower}. Upper bit i (code bit 12+i) is the XOR of every data bit whose 12-bit position {byte offset, bit index} has bit i set. Lower bit i (code bit i) is the XOR of every data bit whose position has bit i clear.
- R3: An all-0xFF sector produces the code 0xFFFFFF, and checking it against a stored 0xFFFFFF reports clean.
- R4: Let diff be `code_o` XOR `stored_code_i`. When diff is zero, the status is clean (2'b00).
- R5: When diff[23:12] XOR diff[11:0] equals 0xFFF and diff[23:15] is below SECTOR_BYTES, the status is corrected (2'b01). `err_byte_o` is then diff[23:15] and `err_bit_o` is diff[14:12].
- R6: When the halves XOR to 0xFFF but diff[23:15] is not below SECTOR_BYTES, the status is uncorrectable (2'b11).
- R7: A nonzero diff that fails the half test and has exactly one bit set reports a stored-code error (2'b10). In that case, and in every status other than corrected, the location outputs are zero.
- R8: Any other nonzero diff reports uncorrectable (2'b11).
- R9: A start pulse clears the parity, the byte count, `done_o` and `res_vld_o`. A byte strobe or check request in the same cycle as start is dropped.
- R10: A check request taken while `done_o` is high and no result is held sets `res_vld_o` and the status one clock later. The result then holds until the next start, and further requests are ignored. A request made before `done_o` is ignored.
- R11: Byte strobes that arrive while `done_o` is high leave `code_o` unchanged.
- R12: After reset, `done_o` and `res_vld_o` are low, the status is 2'b00, and `code_o` is 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms a new sector calculation |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Sector data byte |
| chk_req_i | input | 1 | Request to compare with the stored code |
| stored_code_i | input | 24 | Code read back from the spare area |
| code_o | output | 24 | Computed, packed and inverted code |
| done_o | output | 1 | Whole sector has been accepted |
| res_vld_o | output | 1 | Check result is held |
| status_o | output | 2 | 00 clean, 01 corrected, 10 stored-code error, 11 uncorrectable |
| err_byte_o | output | 9 | Byte offset of the bit to flip |
| err_bit_o | output | 3 | Bit index within that byte |

## Verification
Start shares its cycle with the other two inputs. A start pulse can land in the same clock as a byte strobe or as a check request, and start must win both times. The bench raises start together with a check request on a completed sector and expects no result and a cleared done flag. It also raises start together with a strobe and confirms that done appears only after a further full sector of strobes. A second instance with a 256-byte sector drives the correctable-offset range check to its failing side.

// File: rtl/necc_pkg.sv
package necc_pkg;
  typedef enum logic [1:0] {
    CHK_CLEAN     = 2'b00,
    CHK_FIXED     = 2'b01,
    CHK_CODE_ONLY = 2'b10,
    CHK_FATAL     = 2'b11
  } chk_status_e;
endpackage

// File: rtl/ecc_sector_count.sv
module ecc_sector_count #(
  parameter int SECTOR_BYTES = 512,
  parameter int OFFS_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              strobe_i,
  output logic              take_o,
  output logic [OFFS_W-1:0] index_o,
  output logic              done_o
);
  localparam logic [OFFS_W-1:0] LAST_IDX = OFFS_W'(SECTOR_BYTES - 1);

  logic [OFFS_W-1:0] cnt_q, cnt_n;
  logic              done_q, done_n;
  logic              cnt_en;

  assign take_o  = strobe_i && !done_q && !start_i;
  assign index_o = cnt_q;
  assign done_o  = done_q;
  assign cnt_en  = start_i || take_o;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    if (start_i) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (take_o) begin
      cnt_n  = cnt_q + 1'b1;
      done_n = (cnt_q == LAST_IDX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  // R1: once done, only a start pulse can drop it
  p_done_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);
endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
  parameter int OFFS_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                take_i,
  input  logic [OFFS_W-1:0]   index_i,
  input  logic [7:0]          byte_i,
  output logic [OFFS_W+2:0]   hi_o,
  output logic [OFFS_W+2:0]   lo_o
);
  localparam int HALF_W = OFFS_W + 3;

  logic [HALF_W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic              acc_en;

  assign acc_en = clear_i || take_i;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // each set data bit folds its position into the upper half and the
  // complement of its position into the lower half
  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (clear_i) begin
      hi_n = '0;
      lo_n = '0;
    end else if (take_i) begin
      for (int j = 0; j < 8; j++) begin
        hi_n = hi_n ^ ({index_i, 3'(j)} & {HALF_W{byte_i[j]}});
        lo_n = lo_n ^ (~{index_i, 3'(j)} & {HALF_W{byte_i[j]}});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (acc_en) begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  // R11: without an accepted byte or a clear the parity must not move
  p_acc_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !clear_i) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import necc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int OFFS_W       = 9
) (
  input  logic [2*OFFS_W+5:0] computed_i,
  input  logic [2*OFFS_W+5:0] stored_i,
  output chk_status_e         status_o,
  output logic [OFFS_W-1:0]   err_byte_o,
  output logic [2:0]          err_bit_o
);
  localparam int HALF_W = OFFS_W + 3;
  localparam int CODE_W = 2 * HALF_W;

  logic [CODE_W-1:0] diff;
  logic [CODE_W-1:0] diff_m1;
  logic [HALF_W-1:0] half_x;
  logic [OFFS_W-1:0] offs;
  logic              in_range;
  logic              single_bit;

  assign diff       = computed_i ^ stored_i;
  assign diff_m1    = diff - 1'b1;
  assign half_x     = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign offs       = diff[CODE_W-1:HALF_W+3];
  assign in_range   = {1'b0, offs} < (OFFS_W+1)'(SECTOR_BYTES);
  assign single_bit = (diff != '0) && ((diff & diff_m1) == '0);

  always_comb begin
    status_o   = CHK_CLEAN;
    err_byte_o = '0;
    err_bit_o  = '0;
    if (diff == '0) begin
      status_o = CHK_CLEAN;
    end else if (&half_x) begin
      if (in_range) begin
        status_o   = CHK_FIXED;
        err_byte_o = offs;
        err_bit_o  = diff[HALF_W+2:HALF_W];
      end else begin
        status_o = CHK_FATAL;
      end
    end else if (single_bit) begin
      status_o = CHK_CODE_ONLY;
    end else begin
      status_o = CHK_FATAL;
    end
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import necc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int OFFS_W       = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  input  logic                 chk_req_i,
  input  logic [2*OFFS_W+5:0]  stored_code_i,
  output logic [2*OFFS_W+5:0]  code_o,
  output logic                 done_o,
  output logic                 res_vld_o,
  output logic [1:0]           status_o,
  output logic [OFFS_W-1:0]    err_byte_o,
  output logic [2:0]           err_bit_o
);
  localparam int HALF_W = OFFS_W + 3;

  logic              take;
  logic [OFFS_W-1:0] index;
  logic              done;
  logic [HALF_W-1:0] hi, lo;
  chk_status_e       cls_status;
  logic [OFFS_W-1:0] cls_byte;
  logic [2:0]        cls_bit;

  logic              res_vld_q, res_vld_n;
  chk_status_e       status_q, status_n;
  logic [OFFS_W-1:0] byte_q, byte_n;
  logic [2:0]        bit_q, bit_n;
  logic              res_en, capture;

  ecc_sector_count #(.SECTOR_BYTES(SECTOR_BYTES), .OFFS_W(OFFS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(byte_vld_i),
    .take_o(take), .index_o(index), .done_o(done)
  );

  ecc_parity_acc #(.OFFS_W(OFFS_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .take_i(take),
    .index_i(index), .byte_i(byte_i), .hi_o(hi), .lo_o(lo)
  );

  assign code_o = ~{hi, lo};

  ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES), .OFFS_W(OFFS_W)) u_cls (
    .computed_i(code_o), .stored_i(stored_code_i),
    .status_o(cls_status), .err_byte_o(cls_byte), .err_bit_o(cls_bit)
  );

  assign capture = chk_req_i && done && !res_vld_q && !start_i;
  assign res_en  = start_i || capture;

  always_comb begin
    res_vld_n = res_vld_q;
    status_n  = status_q;
    byte_n    = byte_q;
    bit_n     = bit_q;
    if (start_i) begin
      res_vld_n = 1'b0;
      status_n  = CHK_CLEAN;
      byte_n    = '0;
      bit_n     = '0;
    end else if (capture) begin
      res_vld_n = 1'b1;
      status_n  = cls_status;
      byte_n    = cls_byte;
      bit_n     = cls_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_q <= 1'b0;
      status_q  <= CHK_CLEAN;
      byte_q    <= '0;
      bit_q     <= '0;
    end else if (res_en) begin
      res_vld_q <= res_vld_n;
      status_q  <= status_n;
      byte_q    <= byte_n;
      bit_q     <= bit_n;
    end
  end

  assign done_o     = done;
  assign res_vld_o  = res_vld_q;
  assign status_o   = status_q;
  assign err_byte_o = byte_q;
  assign err_bit_o  = bit_q;

  // R10: an accepted request yields a result one clock later
  p_result_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req_i && done_o && !res_vld_o && !start_i) |=> res_vld_o);

  // R10: a held result does not change until start
  p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && !start_i) |=> (res_vld_o && $stable(status_o) &&
                                 $stable(err_byte_o) && $stable(err_bit_o)));

  // R10: no result exists without a finished sector
  p_no_early_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !res_vld_o);

  // R9: start leaves nothing completed behind
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !res_vld_o));

  // R6: a reported fix never points past the sector
  p_fix_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && status_o == 2'b01) |->
      ({1'b0, err_byte_o} < (OFFS_W+1)'(SECTOR_BYTES)));
endmodule

// File: tb/sim_nand_hamming_ecc.sv
module sim_nand_hamming_ecc;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  typedef struct packed {
    logic [2:0]  pat;
    logic [1:0]  mode;   // 0 clean, 1 flip data pa, 2 flip stored bit pa, 3 flip pa and pb
    logic [11:0] pa;
    logic [11:0] pb;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 12'h000, 12'h000, 2'b00},
    '{3'd1, 2'd0, 12'h000, 12'h000, 2'b00},
    '{3'd3, 2'd1, 12'h000, 12'h000, 2'b01},
    '{3'd1, 2'd1, 12'hFFF, 12'h000, 2'b01},
    '{3'd4, 2'd1, 12'h5A3, 12'h000, 2'b01},
    '{3'd2, 2'd2, 12'h005, 12'h000, 2'b10},
    '{3'd3, 2'd2, 12'h017, 12'h000, 2'b10},
    '{3'd1, 2'd3, 12'h010, 12'h7F1, 2'b11},
    '{3'd0, 2'd1, 12'h123, 12'h000, 2'b01}
  };

  logic        clk, rst_n;
  logic        start0, start1, vld, chk;
  logic [7:0]  data;
  logic [23:0] stored;
  logic [23:0] code0, code1;
  logic        done0, done1, rv0, rv1;
  logic [1:0]  st0, st1;
  logic [8:0]  eb0, eb1;
  logic [2:0]  ebit0, ebit1;

  int n_run, n_fail;
  bit finished;
  logic [7:0] mem [0:NB-1];

  nand_hamming_ecc u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start0), .byte_vld_i(vld), .byte_i(data),
    .chk_req_i(chk), .stored_code_i(stored), .code_o(code0), .done_o(done0),
    .res_vld_o(rv0), .status_o(st0), .err_byte_o(eb0), .err_bit_o(ebit0)
  );

  nand_hamming_ecc #(.SECTOR_BYTES(256), .OFFS_W(9)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .byte_vld_i(vld), .byte_i(data),
    .chk_req_i(chk), .stored_code_i(stored), .code_o(code1), .done_o(done1),
    .res_vld_o(rv1), .status_o(st1), .err_byte_o(eb1), .err_bit_o(ebit1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(logic [2:0] pat, int idx);
    case (pat)
      3'd0:    return 8'hFF;
      3'd1:    return idx[7:0];
      3'd2:    return 8'h00;
      3'd3:    return 8'((idx * 7) ^ (idx >> 3));
      default: return 8'hA5 ^ idx[8:1];
    endcase
  endfunction

  // parity per address bit, straight from the definition
  function automatic logic [23:0] model_code(int n);
    logic [11:0] hi, lo;
    hi = '0;
    lo = '0;
    for (int i = 0; i < 12; i++) begin
      for (int p = 0; p < n * 8; p++) begin
        if (p[i]) hi[i] = hi[i] ^ mem[p / 8][p % 8];
        else      lo[i] = lo[i] ^ mem[p / 8][p % 8];
      end
    end
    return ~{hi, lo};
  endfunction

  function automatic string req_of(logic [1:0] s);
    case (s)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic pulse_start(bit a, bit b);
    @(negedge clk);
    start0 = a;
    start1 = b;
    @(negedge clk);
    start0 = 1'b0;
    start1 = 1'b0;
  endtask

  task automatic feed(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 5 == 4)) begin
        @(negedge clk);
        vld = 1'b0;
      end
      @(negedge clk);
      vld  = 1'b1;
      data = mem[i];
    end
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic request(logic [23:0] s);
    stored = s;
    @(negedge clk);
    chk = 1'b1;
    @(negedge clk);
    chk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] clean_c, exp_c, st, dif;
    logic [11:0] p;
    n_run = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; start0 = 0; start1 = 0; vld = 0; chk = 0; data = 0; stored = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    expect_eq("R12 done", {31'd0, done0}, 32'd0);
    expect_eq("R12 res_vld", {31'd0, rv0}, 32'd0);
    expect_eq("R12 status", {30'd0, st0}, 32'd0);
    expect_eq("R12 code", {8'd0, code0}, 32'hFFFFFF);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < NB; i++) mem[i] = gen(VECS[v].pat, i);
      clean_c = model_code(NB);
      if (VECS[v].mode == 2'd1 || VECS[v].mode == 2'd3)
        mem[VECS[v].pa[11:3]][VECS[v].pa[2:0]] = ~mem[VECS[v].pa[11:3]][VECS[v].pa[2:0]];
      if (VECS[v].mode == 2'd3)
        mem[VECS[v].pb[11:3]][VECS[v].pb[2:0]] = ~mem[VECS[v].pb[11:3]][VECS[v].pb[2:0]];
      exp_c = model_code(NB);
      st = (VECS[v].mode == 2'd2) ? (clean_c ^ (24'd1 << VECS[v].pa[4:0])) : clean_c;
      if (VECS[v].pat == 3'd0 && VECS[v].mode == 2'd0) begin
        st = 24'hFFFFFF;
        expect_eq("R3 erased code", {8'd0, exp_c}, 32'hFFFFFF);
      end
      pulse_start(1'b1, 1'b0);
      feed(NB, VECS[v].pat[0]);
      expect_eq("R1 done after sector", {31'd0, done0}, 32'd1);
      expect_eq("R2 code", {8'd0, code0}, {8'd0, exp_c});
      request(st);
      expect_eq("R10 result valid", {31'd0, rv0}, 32'd1);
      expect_eq(req_of(VECS[v].exp), {30'd0, st0}, {30'd0, VECS[v].exp});
      if (VECS[v].mode == 2'd1) begin
        expect_eq("R5 byte", {23'd0, eb0}, {23'd0, VECS[v].pa[11:3]});
        expect_eq("R5 bit", {29'd0, ebit0}, {29'd0, VECS[v].pa[2:0]});
      end else begin
        expect_eq("R7 location zero", {20'd0, eb0, ebit0}, 32'd0);
      end
    end

    // R1 exact count, R11 extra strobes
    for (int i = 0; i < NB; i++) mem[i] = gen(3'd4, i);
    exp_c = model_code(NB);
    pulse_start(1'b1, 1'b0);
    feed(NB - 1, 1'b0);
    expect_eq("R1 not done at 511", {31'd0, done0}, 32'd0);
    for (int i = 0; i < NB; i++) mem[i] = (i == 0) ? gen(3'd4, NB - 1) : 8'h3C;
    feed(1, 1'b0);
    expect_eq("R1 done at 512", {31'd0, done0}, 32'd1);
    feed(20, 1'b0);
    expect_eq("R11 code frozen", {8'd0, code0}, {8'd0, exp_c});

    // R10 held result ignores later requests and new stored code
    request(exp_c);
    expect_eq("R10 first result", {30'd0, st0}, 32'd0);
    request(exp_c ^ 24'h000003);
    expect_eq("R10 held status", {30'd0, st0}, 32'd0);
    expect_eq("R10 still valid", {31'd0, rv0}, 32'd1);

    // R10 request before done ignored
    pulse_start(1'b1, 1'b0);
    feed(10, 1'b0);
    request(24'h0);
    expect_eq("R10 early request ignored", {31'd0, rv0}, 32'd0);

    // R9 start with check request in the same cycle
    for (int i = 0; i < NB; i++) mem[i] = gen(3'd1, i);
    feed(NB, 1'b0);
    expect_eq("R9 setup done", {31'd0, done0}, 32'd1);
    stored = code0;
    @(negedge clk);
    start0 = 1'b1; chk = 1'b1;
    @(negedge clk);
    start0 = 1'b0; chk = 1'b0;
    expect_eq("R9 check dropped", {31'd0, rv0}, 32'd0);
    expect_eq("R9 done cleared", {31'd0, done0}, 32'd0);
    expect_eq("R9 parity cleared", {8'd0, code0}, 32'hFFFFFF);

    // R9 start with byte strobe in the same cycle
    @(negedge clk);
    start0 = 1'b1; vld = 1'b1; data = 8'h5A;
    @(negedge clk);
    start0 = 1'b0; vld = 1'b0;
    feed(NB - 1, 1'b0);
    expect_eq("R9 strobe dropped", {31'd0, done0}, 32'd0);

    // R5 and R6 on the short-sector instance
    for (int i = 0; i < NB; i++) mem[i] = gen(3'd1, i);
    pulse_start(1'b0, 1'b1);
    feed(256, 1'b0);
    expect_eq("R1 short done", {31'd0, done1}, 32'd1);
    expect_eq("R2 short code", {8'd0, code1}, {8'd0, model_code(256)});
    p = 12'h9AB;
    dif = {p, ~p};
    request(code1 ^ dif);
    expect_eq("R6 out of range", {30'd0, st1}, 32'd3);
    pulse_start(1'b0, 1'b1);
    feed(256, 1'b0);
    p = 12'h3C5;
    dif = {p, ~p};
    request(code1 ^ dif);
    expect_eq("R5 short fixed", {30'd0, st1}, 32'd1);
    expect_eq("R5 short byte", {23'd0, eb1}, 32'h78);
    expect_eq("R5 short bit", {29'd0, ebit1}, 32'd5);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule